// File: doc/BRIEF.md
# Serial Command Frame Front End

This block is the slave side of a four-wire serial link for a two-channel digital rheostat controller. It runs on the system clock and brings the serial clock, the active-low select and the serial data input into that clock domain through a synchroniser. It detects the rising edges of the serial clock and shifts one bit in on each edge while select is low, most significant bit first. When select goes high it checks the frame. A frame of exactly 24 bits is split into an operation code, a channel address and a data word. These fields go to the execution logic with a single-cycle valid pulse. A frame of any other length is dropped.

The serial output is open-drain: the block either pulls the line low or releases it. For most operations the output gives back, in the next frame, the 24 bits received in the frame before, delayed by one whole frame, so several devices can be chained. After a readback operation (code 9 or 10), the next frame instead carries a readback word. That word holds the stored code, the stored address and a 16-bit value that the execution logic supplies on `rdData`. The block samples `rdData` when that next frame opens.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After reset `cmdValid` is 0, `spiSdoLow` is 0 and `cmdOp`, `cmdAddr` and `cmdData` are all zero.
- R2: In a 24-bit frame, received MSB first, bits [23:20] appear on `cmdOp`, bits [19:16] on `cmdAddr` and bits [15:0] on `cmdData`. A one-cycle `cmdValid` pulse follows once select has returned high. The fields keep their values until the next accepted frame.
- R3: Serial clock edges while select is high neither shift data nor count toward a frame.
- R4: A frame holding fewer or more than 24 clock edges when select rises produces no `cmdValid`, and the command fields keep their earlier values.
- R5: `cmdValid` is never high for two cycles in a row, and there is at most one pulse per frame.
- R6: For an accepted frame whose code is neither 9 nor 10, the output in the following frame presents the previous 24 received bits MSB first. The line is released for a 1 bit and pulled low for a 0 bit. The next bit appears after each serial clock rising edge.
- R7: After an accepted frame with code 9 or 10, the following frame presents the 24-bit word {code, address, `rdData`} MSB first. `rdData` is sampled when that frame's select falls.
- R8: The output is released (`spiSdoLow` = 0) whenever select has been high for longer than the synchroniser delay.
- R9: Only codes 9 and 10 select readback. All of the other 14 codes, including 8 and 11, give the daisy-chain output of R6.
- R10: All four address bits and all sixteen data bits are passed on unchanged. This covers channel address 0 and 1 and any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiClk | input | 1 | Serial clock; data sampled on its rising edge |
| spiCsN | input | 1 | Active-low frame select |
| spiSdi | input | 1 | Serial data in, MSB first |
| spiSdoLow | output | 1 | 1 pulls the open-drain serial output low, 0 releases it |
| rdData | input | DATA_W (16) | Readback value, sampled at the start of the frame after a read code |
| cmdValid | output | 1 | One-cycle pulse for an accepted frame |
| cmdOp | output | OP_W (4) | Operation code field |
| cmdAddr | output | ADDR_W (4) | Channel address field |
| cmdData | output | DATA_W (16) | Data field |

## Verification
The bench builds the block with its default widths: a 4-bit code, a 4-bit address, a 16-bit data field, a 24-bit frame and a two-stage synchroniser. With a 4-bit code, all sixteen codes can be swept against both channel addresses, so every transition between a readback frame and a daisy-chain frame occurs at least once. The short frame keeps it cheap to add 0-, 23- and 25-edge frames, serial clocks while select is high, and full-width address and data patterns. For each of these the serial output of the next frame is compared with an arithmetic model.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  // Control-to-datapath strobes, all single-cycle
  typedef struct packed {
    logic frameStart;  // select just fell
    logic shift;       // serial clock rose inside a frame
    logic frameEnd;    // select just rose
    logic commit;      // frameEnd with exact frame length
    logic loadRead;    // frameStart with a readback owed
  } frameStb_t;

endpackage

// File: rtl/spi_frame_sync.sv
module spi_frame_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= RESET_VAL;
          else       stageQ[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= RESET_VAL;
          else       stageQ[g] <= stageQ[g-1];
        end
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int FRAME_W = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csSync,
  input  logic      sclkSync,
  input  logic      rxIsRead,
  output frameStb_t stb,
  output logic      cmdValid
);

  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_OVER} frameState_e;

  frameState_e stateQ;
  logic        csPrevQ;
  logic        sclkPrevQ;
  logic [CNT_W-1:0] bitCntQ;
  logic        readPendQ;

  always_comb begin
    stb.frameStart = csPrevQ & ~csSync;
    stb.frameEnd   = ~csPrevQ & csSync;
    stb.shift      = ~csSync & sclkSync & ~sclkPrevQ;
    stb.commit     = stb.frameEnd & (stateQ == ST_RECV) & (bitCntQ == CNT_FULL);
    stb.loadRead   = stb.frameStart & readPendQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrevQ   <= 1'b1;
      sclkPrevQ <= 1'b0;
    end else begin
      csPrevQ   <= csSync;
      sclkPrevQ <= sclkSync;
    end
  end

  // Bit counter saturates one past a full frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCntQ <= '0;
      stateQ  <= ST_IDLE;
    end else if (stb.frameStart) begin
      bitCntQ <= stb.shift ? CNT_W'(1) : '0;
      stateQ  <= ST_RECV;
    end else if (stb.frameEnd) begin
      stateQ  <= ST_IDLE;
    end else if (stb.shift && stateQ == ST_RECV) begin
      if (bitCntQ == CNT_FULL) begin
        bitCntQ <= CNT_OVER;
        stateQ  <= ST_OVER;
      end else begin
        bitCntQ <= bitCntQ + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                readPendQ <= 1'b0;
    else if (stb.commit)      readPendQ <= rxIsRead;
    else if (stb.frameStart)  readPendQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdValid <= 1'b0;
    else       cmdValid <= stb.commit;
  end

endmodule

// File: rtl/spi_frame_dp.sv
module spi_frame_dp
  import spi_frame_pkg::*;
#(
  parameter int OP_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int RD_OP_A = 9,
  parameter int RD_OP_B = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStb_t         stb,
  input  logic              csSync,
  input  logic              sdiSync,
  input  logic [DATA_W-1:0] rdData,
  output logic              rxIsRead,
  output logic [OP_W-1:0]   cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic              sdoLow
);

  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
  localparam int OP_LSB = ADDR_W + DATA_W;

  logic [FRAME_W-1:0] shiftQ;
  logic [FRAME_W-1:0] readWord;
  logic [FRAME_W-1:0] shiftBase;
  logic [OP_W-1:0]    rxOp;

  assign readWord  = {cmdOp, cmdAddr, rdData};
  assign shiftBase = stb.loadRead ? readWord : shiftQ;
  assign rxOp      = shiftQ[FRAME_W-1 -: OP_W];
  assign rxIsRead  = (rxOp == OP_W'(RD_OP_A)) || (rxOp == OP_W'(RD_OP_B));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftQ <= '0;
    else if (stb.shift)    shiftQ <= {shiftBase[FRAME_W-2:0], sdiSync};
    else if (stb.loadRead) shiftQ <= readWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOp   <= '0;
      cmdAddr <= '0;
      cmdData <= '0;
    end else if (stb.commit) begin
      cmdOp   <= rxOp;
      cmdAddr <= shiftQ[OP_LSB-1 -: ADDR_W];
      cmdData <= shiftQ[DATA_W-1:0];
    end
  end

  assign sdoLow = ~csSync & ~shiftQ[FRAME_W-1];

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_frame_pkg::*;
#(
  parameter int OP_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RD_OP_A = 9,
  parameter int RD_OP_B = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiClk,
  input  logic              spiCsN,
  input  logic              spiSdi,
  output logic              spiSdoLow,
  input  logic [DATA_W-1:0] rdData,
  output logic              cmdValid,
  output logic [OP_W-1:0]   cmdOp,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData
);

  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;

  logic [2:0] pinSync;
  logic       csSync, sclkSync, sdiSync;
  logic       rxIsRead;
  frameStb_t  stb;

  spi_frame_sync #(
    .STAGES(SYNC_STAGES), .WIDTH(3), .RESET_VAL(3'b100)
  ) i_sync (
    .clk(clk), .rstN(rstN),
    .din({spiCsN, spiClk, spiSdi}),
    .dout(pinSync)
  );

  assign {csSync, sclkSync, sdiSync} = pinSync;

  spi_frame_ctrl #(.FRAME_W(FRAME_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .csSync(csSync), .sclkSync(sclkSync), .rxIsRead(rxIsRead),
    .stb(stb), .cmdValid(cmdValid)
  );

  spi_frame_dp #(
    .OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .RD_OP_A(RD_OP_A), .RD_OP_B(RD_OP_B)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .csSync(csSync), .sdiSync(sdiSync), .rdData(rdData),
    .rxIsRead(rxIsRead),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .sdoLow(spiSdoLow)
  );

endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk #(
  parameter int FRAME_W = 24,
  parameter int SYNC_STAGES = 2,
  parameter int FIELD_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               spiCsN,
  input logic               sdoLow,
  input logic               cmdValid,
  input logic [FIELD_W-1:0] fields,
  input logic               shiftStb,
  input logic               startStb
);

  int csHighRun;
  int edgeRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          csHighRun <= 0;
    else if (!spiCsN)                   csHighRun <= 0;
    else if (csHighRun <= SYNC_STAGES)  csHighRun <= csHighRun + 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          edgeRun <= 0;
    else if (startStb)                  edgeRun <= shiftStb ? 1 : 0;
    else if (shiftStb && edgeRun <= FRAME_W) edgeRun <= edgeRun + 1;
  end

  // R8
  sdo_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csHighRun > SYNC_STAGES) |-> !sdoLow);

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R4
  exact_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (edgeRun == FRAME_W));

  // R2
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> $stable(fields));

endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk #(
  .FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES), .FIELD_W(FRAME_W)
) i_chk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .sdoLow(spiSdoLow),
  .cmdValid(cmdValid), .fields({cmdOp, cmdAddr, cmdData}),
  .shiftStb(stb.shift), .startStb(stb.frameStart)
);

// File: tb/test_spi_cmd_frontend.sv
module test_spi_cmd_frontend;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spiClk = 1'b0;
  logic        spiCsN = 1'b1;
  logic        spiSdi = 1'b0;
  logic        spiSdoLow;
  logic [15:0] rdData = '0;
  logic        cmdValid;
  logic [3:0]  cmdOp;
  logic [3:0]  cmdAddr;
  logic [15:0] cmdData;

  int tests = 0;
  int fails = 0;
  int pulses = 0;

  // bench model
  logic [23:0] modelSr = '0;
  logic        modelPend = 1'b0;
  logic [3:0]  lastOp = '0;
  logic [3:0]  lastAddr = '0;
  logic [15:0] lastData = '0;

  always #5 clk = ~clk;

  spi_cmd_frontend i_spi_cmd_frontend (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiCsN(spiCsN),
    .spiSdi(spiSdi), .spiSdoLow(spiSdoLow), .rdData(rdData),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  always @(posedge clk) if (cmdValid) pulses <= pulses + 1;

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Send nbits edges; bits past 24 are zero. sdoReq names the output rule.
  task automatic doFrame(input logic [23:0] word, input int nbits, input string sdoReq);
    logic [23:0] gotSdo = '0;
    logic [23:0] expSdo = '0;
    int startPulses = pulses;
    logic bitVal;
    if (modelPend) begin
      modelSr = {lastOp, lastAddr, rdData};
    end
    modelPend = 1'b0;
    spiCsN = 1'b0;
    waitCyc(HALF);
    for (int i = 0; i < nbits; i++) begin
      bitVal = (i < 24) ? word[23-i] : 1'b0;
      spiSdi = bitVal;
      waitCyc(HALF);
      if (i < 24) begin
        gotSdo[23-i] = ~spiSdoLow;
        expSdo[23-i] = modelSr[23];
      end
      spiClk = 1'b1;
      modelSr = {modelSr[22:0], bitVal};
      waitCyc(HALF);
      spiClk = 1'b0;
    end
    waitCyc(HALF);
    spiCsN = 1'b1;
    waitCyc(8);
    if (nbits >= 24) check(gotSdo == expSdo, sdoReq, 32'(gotSdo), 32'(expSdo));
    // R8: released once select is high
    check(spiSdoLow == 1'b0, "R8", 32'(spiSdoLow), 32'd0);
    if (nbits == 24) begin
      // R2 / R5 / R10: one pulse and all fields intact
      check(pulses - startPulses == 1, "R5", 32'(pulses - startPulses), 32'd1);
      check({cmdOp, cmdAddr, cmdData} == word, "R2 R10", 32'({cmdOp, cmdAddr, cmdData}),
            32'(word));
      lastOp = word[23:20];
      lastAddr = word[19:16];
      lastData = word[15:0];
      modelPend = (word[23:20] == 4'd9) || (word[23:20] == 4'd10);
    end else begin
      // R4: dropped frame leaves fields alone
      check(pulses == startPulses, "R4 pulse", 32'(pulses - startPulses), 32'd0);
      check({cmdOp, cmdAddr, cmdData} == {lastOp, lastAddr, lastData}, "R4 fields",
            32'({cmdOp, cmdAddr, cmdData}), 32'({lastOp, lastAddr, lastData}));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    string req;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(2);
    // R1
    check(cmdValid == 1'b0 && spiSdoLow == 1'b0, "R1 outputs",
          32'({cmdValid, spiSdoLow}), 32'd0);
    check({cmdOp, cmdAddr, cmdData} == 24'h0, "R1 fields",
          32'({cmdOp, cmdAddr, cmdData}), 32'd0);

    // Sweep every code against both channel addresses (R2, R6, R7, R9)
    for (int op = 0; op < 16; op++) begin
      for (int ad = 0; ad < 2; ad++) begin
        rdData = 16'hB00F ^ 16'(op * 16'h0111 + ad * 16'h0F0F);
        req = modelPend ? "R7" : ((lastOp == 4'd8 || lastOp == 4'd11) ? "R9" : "R6");
        doFrame({4'(op), 4'(ad), 16'h03C5 ^ 16'(op << 8) ^ 16'(ad * 16'h5A5A)}, 24, req);
      end
    end

    // R10: full-width address and data
    rdData = 16'h1234;
    doFrame({4'h3, 4'hF, 16'hFFFF}, 24, "R6");
    doFrame({4'h9, 4'hE, 16'h0001}, 24, "R6");

    // R4: short frame after a read (readback consumed), long and empty frames
    rdData = 16'hC0DE;
    doFrame({4'h1, 4'h1, 16'h2222}, 23, "R7");
    doFrame({4'hA, 4'h0, 16'h7E81}, 25, "R6");
    doFrame(24'h0, 0, "R4");
    doFrame({4'h2, 4'h1, 16'h0155}, 24, "R6");

    // R3: serial clocks with select high, then the output must still
    // show the previous frame unshifted
    for (int i = 0; i < 5; i++) begin
      spiSdi = 1'b1;
      spiClk = 1'b1;
      waitCyc(HALF);
      spiClk = 1'b0;
      waitCyc(HALF);
    end
    check(pulses > 0, "R3 pulses seen", 32'(pulses), 32'd1);
    doFrame({4'h0, 4'h0, 16'h8001}, 24, "R3");

    // R7: back-to-back reads
    rdData = 16'hA5C3;
    doFrame({4'hA, 4'h1, 16'h0000}, 24, "R6");
    rdData = 16'h3C5A;
    doFrame({4'h9, 4'h0, 16'h0000}, 24, "R7");
    doFrame({4'h4, 4'h0, 16'h0000}, 24, "R7");

    summary();
  end

endmodule